// File: doc/BRIEF.md
# Probabilistic Write-Cache Admission Unit

This unit sits in front of a small write cache and decides, for every incoming write request, what happens to the data. A write whose start block is already cached refreshes that entry. A write that is too large goes straight to main storage. Any other write must pass a pseudo-random trial before it is admitted. An address that is written often passes the trial sooner or later. Data written rarely seldom gets in. No history is kept per address.

The unit holds a fully associative tag store with least-recently-used replacement. For each request it reports one decision one cycle later. The decision is one of: update of a cached entry, insertion of a new entry, or bypass to storage. It also reports whether cached entries overlapping the request were invalidated, and the tag of any entry that was evicted. The admission probability can be a single programmed fraction paired with a byte cut-off. It can also be chosen per size class from a small table, in which case the class count takes over the role of the cut-off. Moving the data and driving the flash are handled elsewhere.

Each request follows exactly one decision path:
- The update path is taken on a hit.
- The cold-bypass path is taken on a miss that is too large.
- The admit path is taken on a miss that passes the trial.
- The reject-bypass path is taken on a miss that fails the trial.

Top module: `wcache_admit`

## Requirements
- R1: While reset is held, `dec_valid` and `evict_valid` are low, the tag store is empty and the random generator is loaded with the parameter `SEED`.
- R2: Each cycle with `req_valid` high yields exactly one decision, registered: `dec_valid` is high in the following cycle. A cycle without a request gives `dec_valid` low in the next cycle.
- R3: A request whose `req_addr` equals the tag of a valid entry is a hit. It gives `dec_kind` = 0 (update) whatever its size, invalidates nothing and makes the entry most recently used.
- R4: The request spans `nblk` = max(1, ceil(`req_size` / 4096)) blocks, starting at `req_addr`. In single mode (`class_mode` = 0), a miss with `req_size` >= `cutoff` gives `dec_kind` = 2 (bypass). It invalidates every cached tag t with `req_addr` <= t < `req_addr` + `nblk`, and `dec_inval` is high only if at least one tag was removed.
- R5: The trial value r is the generator state minus one. The generator is a 16-bit right-shifting Galois LFSR with feedback mask 0xB400. It steps once for every request, hits included, after its value has been used. A miss passes the trial only if r < p, so p = 0xFFFF always admits and p = 0 never admits.
- R6: A miss that passes the trial gives `dec_kind` = 1 (insert). The block first invalidates the overlapping tags, as in R4, then stores `req_addr` as the most recently used entry.
- R7: A miss that fails the trial gives `dec_kind` = 2 (bypass) and invalidates overlapping tags, as in R4.
- R8: In class mode (`class_mode` = 1), `cutoff` is ignored. The class k is the smallest k with 2^k >= `nblk`. A request with k >= 4 is cold. Otherwise p = `prob_vec[16k+15:16k]`.
- R9: An insertion into a full cache (4 entries) that removed no overlapping tag evicts the least recently used entry. It then raises `evict_valid` and reports that entry's tag on `evict_tag`.
- R10: An insertion that invalidates at least one overlapping tag reuses the freed slot and never evicts in the same decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present this cycle |
| req_addr | input | 20 | Start block address of the write |
| req_size | input | 20 | Write size in bytes |
| class_mode | input | 1 | 0: single probability with cut-off; 1: per-class probability table |
| prob_thr | input | 16 | Single-mode admission probability, fraction of 65536 |
| prob_vec | input | 64 | Four 16-bit class probabilities, class 0 in the low bits |
| cutoff | input | 20 | Single-mode size in bytes at or above which a miss is cold |
| dec_valid | output | 1 | Decision present |
| dec_kind | output | 2 | 0 update, 1 insert, 2 bypass |
| dec_inval | output | 1 | Overlapping cached entries were invalidated |
| evict_valid | output | 1 | An entry was evicted to make room |
| evict_tag | output | 20 | Tag of the evicted entry |

## Verification
Two functions can meet in one decision: making room for an insertion, and invalidating overlaps. An admitted write into a full cache could need a victim while also removing overlapped entries. The bench provokes this by filling all four entries and then admitting a multi-block write whose span covers one cached tag. It expects an insert with `dec_inval` high and no eviction. The reverse case is also checked: a single-block write into a full cache with no overlap must evict the least recently used tag. The bench predicts both outcomes with a queue model ordered by recency, and it steps its own generator model once per request.

// File: rtl/wca_pkg.sv
package wca_pkg;
    typedef enum logic [1:0] {
        DEC_UPDATE = 2'd0,
        DEC_INSERT = 2'd1,
        DEC_BYPASS = 2'd2
    } dec_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_TOUCH = 2'd1,
        OP_DROP  = 2'd2,
        OP_PLACE = 2'd3
    } op_e;
endpackage

// File: rtl/wca_lfsr.sv
module wca_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] state_q;
    logic [W-1:0] state_d;

    always_comb begin
        state_d = state_q;
        if (step) begin
            state_d = state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign state = state_q;

    // R5
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/wca_classify.sv
module wca_classify #(
    parameter int SIZE_W    = 20,
    parameter int BLK_SHIFT = 12,
    parameter int NCLS      = 4,
    parameter int PW        = 16,
    localparam int NB_W     = SIZE_W - BLK_SHIFT + 1,
    localparam int CW       = $clog2(NCLS + 1)
) (
    input  logic [SIZE_W-1:0]  size,
    input  logic               class_mode,
    input  logic [PW-1:0]      prob_thr,
    input  logic [NCLS*PW-1:0] prob_vec,
    input  logic [SIZE_W-1:0]  cutoff,
    output logic [NB_W-1:0]    nblk,
    output logic               cold,
    output logic [PW-1:0]      p_sel
);
    logic [NB_W-1:0] nb_raw;
    logic [CW-1:0]   cls;

    assign nb_raw = {1'b0, size[SIZE_W-1:BLK_SHIFT]} + NB_W'(|size[BLK_SHIFT-1:0]);
    assign nblk   = (nb_raw == '0) ? NB_W'(1) : nb_raw;

    always_comb begin
        cls = CW'(NCLS);
        for (int k = NCLS - 1; k >= 0; k--) begin
            if (32'(nblk) <= (32'd1 << k)) cls = CW'(k);
        end
    end

    always_comb begin
        p_sel = prob_thr;
        cold  = (size >= cutoff);
        if (class_mode) begin
            p_sel = '0;
            cold  = (cls == CW'(NCLS));
            for (int k = 0; k < NCLS; k++) begin
                if (cls == CW'(k)) p_sel = prob_vec[k*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/wca_tagstore.sv
module wca_tagstore
    import wca_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 4,
    parameter int NB_W   = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int IW    = $clog2(DEPTH),
    localparam int EW    = ((ADDR_W > NB_W) ? ADDR_W : NB_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NB_W-1:0]   nblk,
    output logic              hit,
    output logic              ovl_any,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_tag
);
    logic [ADDR_W-1:0] tag_q [DEPTH];
    logic [AW-1:0]     age_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [ADDR_W-1:0] tag_d [DEPTH];
    logic [AW-1:0]     age_d [DEPTH];
    logic [DEPTH-1:0]  vld_d;

    logic [DEPTH-1:0]  match;
    logic [DEPTH-1:0]  ovl;
    logic [DEPTH-1:0]  surv;
    logic [AW-1:0]     cage [DEPTH];
    logic [IW-1:0]     hit_idx;
    logic [IW-1:0]     free_idx;
    logic [IW-1:0]     victim;
    logic [IW-1:0]     slot;
    logic [EW-1:0]     span_end;
    logic              full;

    assign span_end = EW'(addr) + EW'(nblk);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign match[g] = vld_q[g] && (tag_q[g] == addr);
        assign ovl[g]   = vld_q[g] && (tag_q[g] >= addr) && (EW'(tag_q[g]) < span_end);
        assign surv[g]  = vld_q[g] && !ovl[g];
    end

    assign hit     = |match;
    assign ovl_any = |ovl;
    assign full    = &surv;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        victim   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i])                     hit_idx  = IW'(i);
            if (!surv[i])                     free_idx = IW'(i);
            if (age_q[i] == AW'(DEPTH - 1))   victim   = IW'(i);
        end
    end

    assign slot        = full ? victim : free_idx;
    assign evict_valid = (op == OP_PLACE) && full;
    assign evict_tag   = tag_q[victim];

    // ages of survivors closed up over the holes left by invalidation
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            logic [AW-1:0] gap;
            gap = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (ovl[i] && (age_q[i] < age_q[j])) gap = gap + AW'(1);
            end
            cage[j] = age_q[j] - gap;
        end
    end

    always_comb begin
        tag_d = tag_q;
        age_d = age_q;
        vld_d = vld_q;
        unique case (op)
            OP_IDLE: begin
            end
            OP_TOUCH: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (IW'(i) == hit_idx)                        age_d[i] = '0;
                    else if (vld_q[i] && age_q[i] < age_q[hit_idx]) age_d[i] = age_q[i] + AW'(1);
                end
            end
            OP_DROP: begin
                vld_d = surv;
                for (int i = 0; i < DEPTH; i++) age_d[i] = surv[i] ? cage[i] : '0;
            end
            OP_PLACE: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (IW'(i) == slot) begin
                        vld_d[i] = 1'b1;
                        tag_d[i] = addr;
                        age_d[i] = '0;
                    end else begin
                        vld_d[i] = surv[i];
                        age_d[i] = surv[i] ? cage[i] + AW'(1) : '0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i] <= '0;
                age_q[i] <= '0;
            end
        end else begin
            vld_q <= vld_d;
            tag_q <= tag_d;
            age_q <= age_d;
        end
    end

    // R3
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9
    evict_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (vld_q == '1));
endmodule

// File: rtl/wcache_admit.sv
module wcache_admit
    import wca_pkg::*;
#(
    parameter int              ADDR_W    = 20,
    parameter int              SIZE_W    = 20,
    parameter int              BLK_SHIFT = 12,
    parameter int              DEPTH     = 4,
    parameter int              NCLS      = 4,
    parameter int              PW        = 16,
    parameter logic [PW-1:0]   TAPS      = 16'hB400,
    parameter logic [PW-1:0]   SEED      = 16'hACE1,
    localparam int             NB_W      = SIZE_W - BLK_SHIFT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic               class_mode,
    input  logic [PW-1:0]      prob_thr,
    input  logic [NCLS*PW-1:0] prob_vec,
    input  logic [SIZE_W-1:0]  cutoff,
    output logic               dec_valid,
    output logic [1:0]         dec_kind,
    output logic               dec_inval,
    output logic               evict_valid,
    output logic [ADDR_W-1:0]  evict_tag
);
    logic [PW-1:0]     rnd_state;
    logic [PW-1:0]     rnd;
    logic [PW-1:0]     p_sel;
    logic [NB_W-1:0]   nblk;
    logic              cold;
    logic              hit;
    logic              ovl_any;
    logic              ev_valid_d;
    logic [ADDR_W-1:0] ev_tag_d;
    logic              admit;
    op_e               op;
    dec_e              kind_d;
    dec_e              kind_q;

    wca_lfsr #(.W(PW), .TAPS(TAPS), .SEED(SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (req_valid),
        .state (rnd_state)
    );

    wca_classify #(.SIZE_W(SIZE_W), .BLK_SHIFT(BLK_SHIFT), .NCLS(NCLS), .PW(PW)) u_cls (
        .size       (req_size),
        .class_mode (class_mode),
        .prob_thr   (prob_thr),
        .prob_vec   (prob_vec),
        .cutoff     (cutoff),
        .nblk       (nblk),
        .cold       (cold),
        .p_sel      (p_sel)
    );

    wca_tagstore #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .NB_W(NB_W)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .addr        (req_addr),
        .nblk        (nblk),
        .hit         (hit),
        .ovl_any     (ovl_any),
        .evict_valid (ev_valid_d),
        .evict_tag   (ev_tag_d)
    );

    assign rnd   = rnd_state - PW'(1);
    assign admit = (rnd < p_sel);

    always_comb begin
        op     = OP_IDLE;
        kind_d = DEC_BYPASS;
        if (req_valid) begin
            if (hit) begin
                op     = OP_TOUCH;
                kind_d = DEC_UPDATE;
            end else if (cold) begin
                op     = OP_DROP;
                kind_d = DEC_BYPASS;
            end else if (admit) begin
                op     = OP_PLACE;
                kind_d = DEC_INSERT;
            end else begin
                op     = OP_DROP;
                kind_d = DEC_BYPASS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            kind_q      <= DEC_UPDATE;
            dec_inval   <= 1'b0;
            evict_valid <= 1'b0;
            evict_tag   <= '0;
        end else begin
            dec_valid   <= req_valid;
            kind_q      <= kind_d;
            dec_inval   <= ((op == OP_DROP) || (op == OP_PLACE)) && ovl_any;
            evict_valid <= ev_valid_d;
            evict_tag   <= ev_tag_d;
        end
    end

    assign dec_kind = kind_q;

    // R2
    dec_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);
    // R2
    no_spurious_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid);
    // R5
    full_scale_admits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit && !cold && (p_sel == '1)) |=> (dec_kind == DEC_INSERT));
    // R5
    zero_never_admits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit && (p_sel == '0)) |=> (dec_kind == DEC_BYPASS));
    // R3
    hit_updates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit) |=> (dec_kind == DEC_UPDATE && !dec_inval && !evict_valid));
    // R10
    overlap_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit && ovl_any) |=> !evict_valid);
    // R9
    evict_on_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (dec_valid && dec_kind == DEC_INSERT));
endmodule

// File: tb/wcache_admit_tb.sv
`timescale 1ns/1ps
module wcache_admit_tb;
    localparam int ADDR_W = 20;
    localparam int SIZE_W = 20;
    localparam int DEPTH  = 4;
    localparam int NCLS   = 4;
    localparam int PW     = 16;
    localparam logic [15:0] SEED = 16'hACE1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              class_mode = 1'b0;
    logic [PW-1:0]     prob_thr = '0;
    logic [NCLS*PW-1:0] prob_vec = '0;
    logic [SIZE_W-1:0] cutoff = '0;
    logic              dec_valid;
    logic [1:0]        dec_kind;
    logic              dec_inval;
    logic              evict_valid;
    logic [ADDR_W-1:0] evict_tag;

    wcache_admit #(.SEED(SEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .class_mode(class_mode), .prob_thr(prob_thr),
        .prob_vec(prob_vec), .cutoff(cutoff), .dec_valid(dec_valid),
        .dec_kind(dec_kind), .dec_inval(dec_inval), .evict_valid(evict_valid),
        .evict_tag(evict_tag)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int m_rng;
    int m_q[$];

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int blocks_of(int size);
        int n;
        n = (size + 4095) / 4096;
        if (n == 0) n = 1;
        return n;
    endfunction

    task automatic send(int addr, int size, string req);
        int  n, cls, p, r, exp_kind, exp_ev, exp_tag, hit_pos;
        bit  exp_inv, is_cold;
        int  keep[$];
        n = blocks_of(size);
        hit_pos = -1;
        exp_inv = 0; exp_ev = 0; exp_tag = 0;
        foreach (m_q[i]) if (m_q[i] == addr) hit_pos = i;
        if (hit_pos >= 0) begin
            exp_kind = 0;
            m_q.delete(hit_pos);
            m_q.push_front(addr);
        end else begin
            if (class_mode) begin
                cls = NCLS;
                for (int k = NCLS - 1; k >= 0; k--) if ((1 << k) >= n) cls = k;
                is_cold = (cls >= NCLS);
                p = is_cold ? 0 : int'(prob_vec[cls*PW +: PW]);
            end else begin
                is_cold = (size >= int'(cutoff));
                p = int'(prob_thr);
            end
            r = m_rng - 1;
            exp_kind = (!is_cold && r < p) ? 1 : 2;
            foreach (m_q[i]) begin
                if (m_q[i] >= addr && m_q[i] < addr + n) exp_inv = 1;
                else keep.push_back(m_q[i]);
            end
            m_q = keep;
            if (exp_kind == 1) begin
                if (m_q.size() == DEPTH) begin
                    exp_ev = 1;
                    exp_tag = m_q.pop_back();
                end
                m_q.push_front(addr);
            end
        end
        m_rng = (m_rng & 1) ? ((m_rng >> 1) ^ 'hB400) : (m_rng >> 1);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        req_size  = SIZE_W'(size);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "dec_valid", int'(dec_valid), 1);
        check(req, "dec_kind", int'(dec_kind), exp_kind);
        check(req, "dec_inval", int'(dec_inval), int'(exp_inv));
        check(req, "evict_valid", int'(evict_valid), exp_ev);
        if (exp_ev != 0) check(req, "evict_tag", int'(evict_tag), exp_tag);
    endtask

    task automatic idle(string req);
        req_valid = 1'b0;
        @(negedge clk);
        check(req, "dec_valid idle", int'(dec_valid), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_rng = int'(SEED);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "dec_valid in reset", int'(dec_valid), 0);
        check("R1", "evict_valid in reset", int'(evict_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle("R2");

        class_mode = 1'b0;
        cutoff     = 20'd32768;
        prob_thr   = 16'hFFFF;
        send(16, 4096, "R6");
        send(32, 4096, "R6");
        send(48, 4096, "R6");
        send(64, 4096, "R6");
        idle("R2");
        send(32, 40000, "R3");   // hit beats the size cut-off
        send(80, 4096, "R9");    // full, no overlap: evicts tag 16
        send(60, 20000, "R10");  // blocks 60..64 cover tag 64
        send(46, 32768, "R4");   // cold, covers tag 48
        send(100, 32767, "R4");  // one byte under cut-off: admitted
        send(0, 0, "R9");        // full again: evicts LRU
        prob_thr = 16'h0000;
        send(200, 4096, "R5");
        send(78, 12288, "R7");   // blocks 78..80 cover tag 80
        send(100, 4096, "R3");

        prob_thr = 16'h5000;
        for (int k = 0; k < 40; k++) begin
            send(300 + (k * 7) % 13, 4096 * (1 + k % 3), "R5");
        end
        idle("R2");

        class_mode = 1'b1;
        cutoff     = 20'd0;      // ignored in class mode
        prob_vec   = {16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF};
        send(500, 4096, "R8");   // class 0
        send(510, 12288, "R8");  // class 2, p = 0
        send(520, 36864, "R8");  // 9 blocks: cold
        send(530, 32768, "R8");  // class 3
        send(540, 8000, "R8");   // class 1
        send(600, 0, "R8");      // empty size counts as one block
        prob_vec = {16'h3000, 16'h9000, 16'h4000, 16'hC000};
        for (int k = 0; k < 30; k++) begin
            send(700 + (k * 5) % 11, 3000 * (1 + k % 12), "R8");
        end
        idle("R2");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule